// File: doc/BRIEF.md
# Serial EEPROM SPI Command Front-End

This block is the slave side of a four-wire serial link for a 128-byte serial EEPROM. A host selects it by pulling chip select low, clocks in an 8-bit instruction, and then, depending on the instruction, an address and data bytes, or receives a stream of read data or status bytes. The block decodes six instructions and holds the status register: two protection bits, the write-enable flag and a ready flag that mirrors the busy line of the downstream write engine. It turns host traffic into byte-wide read requests to the memory array, byte-wide load requests plus a commit pulse to a page-write engine, and a commit pulse for status writes.

All pins are brought into the system clock domain through a short synchronizer chain, and the serial clock edges are detected there. The serial clock must therefore run well below the system clock: each high and each low phase lasts at least four system clocks. The serial output is a data bit plus an output enable, and a pause input can freeze a transfer part-way through.

Top module: `eep_spi_front`

## Requirements
- R1: Instruction codes are 0x06 set-enable, 0x04 clear-enable, 0x05 status read, 0x01 status write, 0000_x011 array read and 0000_x010 array write (bit 3 ignored). Any other 8-bit code is dropped: no request leaves the block and `so_oe` stays low for the rest of the transaction.
- R2: `si` is captured on the rising `sck` edge, most significant bit first. `so_data` changes after the falling `sck` edge. A status read returns {1111, BP1, BP0, WEL, RDY} (bits 7..0) and repeats it fresh for every further byte.
- R3: `so_oe` is low while `cs_n` is high and whenever no read or status output is in progress.
- R4: Set-enable raises WEL only if `cs_n` rises right after its eighth bit. If more bits follow, WEL is unchanged.
- R5: WEL is cleared by reset, by a clear-enable instruction closed after exactly eight bits, and when `busy` falls at the end of a write cycle.
- R6: A status write closed after exactly 16 bits with WEL = 1 copies data bits 3 and 2 into BP1 and BP0 and pulses `sr_commit`. Other data bits have no effect, and with WEL = 0 nothing changes.
- R7: An array read takes an address byte (bit 7 ignored) and then streams bytes from successive addresses, wrapping from 0x7F to 0x00 for as long as the clock runs.
- R8: An array write with WEL = 1 sends each completed data byte on `wr_req`/`wr_addr`/`wr_data`. The low 4 address bits count up and roll over inside the 16-byte page. `wr_commit` pulses when `cs_n` rises on a byte boundary after at least one byte was sent.
- R9: An array write issued with WEL = 0 produces no `wr_req` and no `wr_commit`.
- R10: Protection by {BP1,BP0}: 01 guards 0x60–0x7F, 10 guards 0x40–0x7F and 11 guards the whole array. Data bytes for guarded addresses are not sent.
- R11: While RDY = 1, every instruction except the status read is dropped. A status read during that time returns RDY = 1.
- R12: Pulling `hold_n` low with `sck` low pauses the transfer: `so_oe` is low and `sck`/`si` activity is ignored. Raising `hold_n` with `sck` low resumes the transfer exactly where it stopped.
- R13: A rising `cs_n` discards a partly shifted instruction or byte. An array write that ends off a byte boundary gives no `wr_commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host (mode 0 or 3) |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| so_data | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so_data`; low means high impedance |
| busy | input | 1 | Write engine is running an internal write cycle |
| rd_req | output | 1 | One-cycle read request to the array |
| rd_addr | output | 7 | Read address |
| rd_data | input | 8 | Array data, valid from the cycle after `rd_req` until the next request |
| wr_req | output | 1 | One-cycle page-buffer load request |
| wr_addr | output | 7 | Load address |
| wr_data | output | 8 | Load data |
| wr_commit | output | 1 | Start programming the loaded page |
| sr_commit | output | 1 | Start a status write cycle |

## Verification
The assertions assume that `busy` rises only after a `wr_commit` or `sr_commit` and is then held for longer than any transaction the host starts. They also assume the host meets the slow-clock rule, so that no `sck` edge is lost in the synchronizer. The stimulus models the write engine to match: every commit starts a fixed 700-cycle busy window. The host tasks hold every `sck` phase for five system clocks and move `hold_n` and `cs_n` only while `sck` is low.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM front-end.
// Assumes an 8-bit instruction byte; the bit-3 don't-care applies to the array commands only.
package eep_pkg;

    typedef enum logic [2:0] {
        CMD_BAD, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
    } cmd_e;

    typedef enum logic [2:0] {
        PH_OPC, PH_ADDR, PH_WDATA, PH_SRDATA, PH_ARMED, PH_RDOUT, PH_STOUT, PH_IGNORE
    } phase_e;

    // Map an instruction byte onto a command; unknown codes give CMD_BAD.
    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        c = CMD_BAD;
        if (op == 8'h06)      c = CMD_WREN;
        else if (op == 8'h04) c = CMD_WRDI;
        else if (op == 8'h05) c = CMD_RDSR;
        else if (op == 8'h01) c = CMD_WRSR;
        else if (op[7:4] == 4'h0 && op[2:0] == 3'b011) c = CMD_READ;
        else if (op[7:4] == 4'h0 && op[2:0] == 3'b010) c = CMD_WRITE;
        return c;
    endfunction

endpackage

// File: rtl/eep_pin_sync.sv
// Pin synchronizer and edge detector.
// Brings cs_n, sck, si and hold_n into clk, reports chip-select and serial-clock
// edges and tracks the pause state. Assumes each sck phase spans at least
// SYNC_STAGES+2 clk cycles so that no edge is missed.
module eep_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic cs_act,
    output logic cs_rise,
    output logic cs_fall,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic hold_act
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] IDLE_LVL = 4'b1001; // {hold_n, si, sck, cs_n}

    logic [SYNC_STAGES-1:0][NSIG-1:0] stg;
    logic [NSIG-1:0] lvl, lvl_q;
    logic cs_n_s, sck_s, hold_s;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= IDLE_LVL;
        end else begin
            for (int s = SYNC_STAGES - 1; s > 0; s--) stg[s] <= stg[s-1];
            stg[0] <= {hold_n, si, sck, cs_n};
        end
    end

    assign lvl    = stg[SYNC_STAGES-1];
    assign cs_n_s = lvl[0];
    assign sck_s  = lvl[1];
    assign si_s   = lvl[2];
    assign hold_s = lvl[3];

    // Keep last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= IDLE_LVL;
        else        lvl_q <= lvl;
    end

    // Pause state: enter or leave only while sck is low and the chip is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_act <= 1'b0;
        else if (cs_n_s) hold_act <= 1'b0;
        else if (!sck_s) hold_act <= !hold_s;
    end

    assign cs_act   = !cs_n_s;
    assign cs_rise  = cs_n_s && !lvl_q[0];
    assign cs_fall  = !cs_n_s && lvl_q[0];
    assign sck_rise = cs_act && !hold_act && sck_s && !lvl_q[1];
    assign sck_fall = cs_act && !hold_act && !sck_s && lvl_q[1];

endmodule

// File: rtl/eep_status.sv
// Status register: protection bits, write-enable flag and ready flag.
// Assumes busy only falls at the end of an internal write cycle; that fall clears WEL.
module eep_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       bp_we,
    input  logic [1:0] bp_d,
    input  logic       busy,
    output logic       wel,
    output logic [1:0] bp,
    output logic       busy_q,
    output logic [7:0] stat
);
    // Register the engine busy line as the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Write-enable flag: end of a write cycle and disable win over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                           wel <= 1'b0;
        else if ((busy_q && !busy) || clr_wel) wel <= 1'b0;
        else if (set_wel)                     wel <= 1'b1;
    end

    // Protection bits, changed only by an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n)     bp <= 2'b00;
        else if (bp_we) bp <= bp_d;
    end

    assign stat = {4'hF, bp, wel, busy_q};

    a_r5_wel_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy) |=> !wel);
    a_r6_bp_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_we |=> $stable(bp));

endmodule

// File: rtl/eep_cmd_engine.sv
// Instruction engine: shifts in opcode, address and data on sck rising edges,
// shifts out read or status bytes on sck falling edges, and issues requests.
// Assumes edges arrive already synchronized and gated by the pause state,
// and that rd_data is valid one clk after rd_req and held until the next one.
module eep_cmd_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si_s,
    input  logic              hold_act,
    input  logic [7:0]        stat,
    input  logic              wel,
    input  logic [1:0]        bp,
    input  logic              busy_q,
    input  logic [7:0]        rd_data,
    output logic              so_data,
    output logic              so_oe,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              sr_commit,
    output logic              set_wel,
    output logic              clr_wel,
    output logic              bp_we,
    output logic [1:0]        bp_d
);
    localparam int AW = ADDR_W;

    phase_e            phase;
    cmd_e              armed;
    logic              is_read;
    logic [2:0]        bitc;
    logic [7:0]        shin;
    logic [7:0]        nxt_byte;
    logic              byte_done;
    logic [AW-1:0]     addr;
    logic              fwd_any;
    logic [2:0]        ocnt;
    logic [6:0]        osr;
    logic              oe_run;
    cmd_e              dec;

    // True when the address lies inside the block selected by the protection bits.
    function automatic logic guarded(input logic [AW-1:0] a, input logic [1:0] b);
        case (b)
            2'b01:   return &a[AW-1 -: 2];
            2'b10:   return a[AW-1];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    assign nxt_byte  = {shin[6:0], si_s};
    assign byte_done = (bitc == 3'd7);
    assign dec       = decode_op(nxt_byte);
    assign so_oe     = oe_run && cs_act && !hold_act;

    // Main sequencer: transaction framing, input shifting, output shifting, requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OPC; armed <= CMD_BAD; is_read <= 1'b0;
            bitc <= '0; shin <= '0; addr <= '0; fwd_any <= 1'b0;
            ocnt <= '0; osr <= '0; oe_run <= 1'b0; so_data <= 1'b0;
            rd_req <= 1'b0; rd_addr <= '0; wr_req <= 1'b0; wr_addr <= '0; wr_data <= '0;
            wr_commit <= 1'b0; sr_commit <= 1'b0; set_wel <= 1'b0; clr_wel <= 1'b0;
            bp_we <= 1'b0; bp_d <= 2'b00;
        end else begin
            rd_req <= 1'b0; wr_req <= 1'b0; wr_commit <= 1'b0; sr_commit <= 1'b0;
            set_wel <= 1'b0; clr_wel <= 1'b0; bp_we <= 1'b0;
            if (cs_rise || cs_fall) begin
                if (cs_rise && phase == PH_ARMED) begin
                    case (armed)
                        CMD_WREN: set_wel <= 1'b1;
                        CMD_WRDI: clr_wel <= 1'b1;
                        CMD_WRSR: if (wel) begin
                            bp_we     <= 1'b1;
                            sr_commit <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (cs_rise && phase == PH_WDATA && bitc == 3'd0 && fwd_any)
                    wr_commit <= 1'b1;
                phase <= PH_OPC; bitc <= '0; fwd_any <= 1'b0;
                ocnt <= '0; oe_run <= 1'b0; is_read <= 1'b0;
            end else if (sck_rise) begin
                bitc <= bitc + 3'd1;
                shin <= nxt_byte;
                case (phase)
                    PH_OPC: if (byte_done) begin
                        if (busy_q && dec != CMD_RDSR) phase <= PH_IGNORE;
                        else begin
                            case (dec)
                                CMD_WREN, CMD_WRDI: begin armed <= dec; phase <= PH_ARMED; end
                                CMD_RDSR:  phase <= PH_STOUT;
                                CMD_WRSR:  phase <= wel ? PH_SRDATA : PH_IGNORE;
                                CMD_READ:  begin is_read <= 1'b1; phase <= PH_ADDR; end
                                CMD_WRITE: phase <= wel ? PH_ADDR : PH_IGNORE;
                                default:   phase <= PH_IGNORE;
                            endcase
                        end
                    end
                    PH_ADDR: if (byte_done) begin
                        addr <= nxt_byte[AW-1:0];
                        if (is_read) begin
                            rd_req  <= 1'b1;
                            rd_addr <= nxt_byte[AW-1:0];
                            phase   <= PH_RDOUT;
                        end else begin
                            phase <= PH_WDATA;
                        end
                    end
                    PH_WDATA: if (byte_done) begin
                        if (!guarded(addr, bp)) begin
                            wr_req  <= 1'b1;
                            wr_addr <= addr;
                            wr_data <= nxt_byte;
                            fwd_any <= 1'b1;
                        end
                        addr <= {addr[AW-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                    end
                    PH_SRDATA: if (byte_done) begin
                        bp_d  <= nxt_byte[3:2];
                        armed <= CMD_WRSR;
                        phase <= PH_ARMED;
                    end
                    PH_ARMED: phase <= PH_IGNORE;
                    default: ;
                endcase
            end else if (sck_fall && (phase == PH_RDOUT || phase == PH_STOUT)) begin
                ocnt   <= ocnt + 3'd1;
                oe_run <= 1'b1;
                if (ocnt == 3'd0) begin
                    if (phase == PH_STOUT) begin
                        so_data <= stat[7];
                        osr     <= stat[6:0];
                    end else begin
                        so_data <= rd_data[7];
                        osr     <= rd_data[6:0];
                        rd_req  <= 1'b1;
                        rd_addr <= addr + 1'b1;
                        addr    <= addr + 1'b1;
                    end
                end else begin
                    so_data <= osr[6];
                    osr     <= {osr[5:0], 1'b0};
                end
            end
        end
    end

    a_r9_load_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wel);
    a_r10_no_guarded_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !guarded(wr_addr, bp));
    a_r11_no_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !(wr_req || wr_commit || sr_commit));
    a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req, wr_commit, sr_commit}));

endmodule

// File: rtl/eep_spi_front.sv
// Top level of the serial EEPROM front-end: pin synchronizer, instruction
// engine and status register. Assumes the serial clock is at least 8x slower
// than clk and that the write engine raises busy only after a commit pulse.
module eep_spi_front #(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so_data,
    output logic              so_oe,
    input  logic              busy,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              sr_commit
);
    localparam int HCNT_W = $clog2(SYNC_STAGES + 2) + 1;

    logic cs_act, cs_rise, cs_fall, sck_rise, sck_fall, si_s, hold_act;
    logic wel, busy_q, set_wel, clr_wel, bp_we;
    logic [1:0] bp, bp_d;
    logic [7:0] stat;

    eep_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .cs_act(cs_act), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .hold_act(hold_act)
    );

    eep_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
        .bp_we(bp_we), .bp_d(bp_d), .busy(busy),
        .wel(wel), .bp(bp), .busy_q(busy_q), .stat(stat)
    );

    eep_cmd_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .hold_act(hold_act),
        .stat(stat), .wel(wel), .bp(bp), .busy_q(busy_q), .rd_data(rd_data),
        .so_data(so_data), .so_oe(so_oe), .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .sr_commit(sr_commit),
        .set_wel(set_wel), .clr_wel(clr_wel), .bp_we(bp_we), .bp_d(bp_d)
    );

    // Count consecutive cycles with the raw chip select high, saturating.
    logic [HCNT_W-1:0] cs_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                 cs_hi_cnt <= '0;
        else if (!cs_n)             cs_hi_cnt <= '0;
        else if (!(&cs_hi_cnt))     cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    a_r3_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt > HCNT_W'(SYNC_STAGES)) |-> !so_oe);
    a_r12_hiz_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act && $past(hold_act)) |-> !so_oe);

endmodule

// File: tb/sim_eep_spi_front.sv
module sim_eep_spi_front;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so_data, so_oe, rd_req, wr_req, wr_commit, sr_commit, busy;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] rd_data = 8'h00, wr_data;

    eep_spi_front u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so_data(so_data), .so_oe(so_oe), .busy(busy),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .sr_commit(sr_commit)
    );

    always #4 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] tx [0:159];
    logic [7:0] rx [0:159];
    int oe_bits, hold_bit = -1, hold_oe;
    logic [7:0] arr [0:127];
    logic [7:0] exp_mem [0:127];
    logic [6:0] pend_a [0:31];
    logic [7:0] pend_d [0:31];
    logic [6:0] log_a [0:31];
    int pend_n = 0, wreq_n = 0, commit_n = 0, srcom_n = 0;
    int busy_cnt = 0;

    assign busy = (busy_cnt != 0);

    // Array and write-engine model.
    always @(posedge clk) begin
        if (rd_req) rd_data <= arr[rd_addr];
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (wr_req) begin
            if (pend_n < 32) begin
                pend_a[pend_n] = wr_addr; pend_d[pend_n] = wr_data; log_a[pend_n] = wr_addr;
            end
            pend_n = pend_n + 1; wreq_n = wreq_n + 1;
        end
        if (wr_commit) begin
            for (int k = 0; k < pend_n && k < 32; k++) arr[pend_a[k]] = pend_d[k];
            commit_n = commit_n + 1; busy_cnt <= 700;
        end
        if (sr_commit) begin
            srcom_n = srcom_n + 1; busy_cnt <= 700;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic do_hold;
        hold_n = 1'b0;
        repeat (6) @(negedge clk);
        if (so_oe) hold_oe++;
        for (int p = 0; p < 3; p++) begin
            sck = 1'b1; si = ~si;
            repeat (4) @(negedge clk);
            if (so_oe) hold_oe++;
            sck = 1'b0;
            repeat (4) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer(input int nbits);
        for (int k = 0; k < 160; k++) rx[k] = 8'h00;
        oe_bits = 0; hold_oe = 0; pend_n = 0; wreq_n = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = tx[i/8][7 - (i%8)];
            repeat (HALF - 1) @(negedge clk);
            if (i == hold_bit) do_hold;
            if (so_oe) begin
                rx[i/8][7 - (i%8)] = so_data;
                oe_bits++;
            end
            @(negedge clk) sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        tx[0] = op; xfer(8);
    endtask

    task automatic rdsr(output logic [7:0] v);
        tx[0] = 8'h05; tx[1] = 8'h00; xfer(16); v = rx[1];
    endtask

    task automatic wait_idle;
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_bp(input logic [1:0] b);
        op1(8'h06);
        tx[0] = 8'h01; tx[1] = {4'h0, b, 2'b00}; xfer(16);
        wait_idle;
    endtask

    function automatic bit guarded(input int a, input int b);
        if (b == 3) return 1;
        if (b == 2) return a >= 'h40;
        if (b == 1) return a >= 'h60;
        return 0;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        int c0;
        for (int a = 0; a < 128; a++) begin
            arr[a] = 8'((a * 37 + 11) % 256);
            exp_mem[a] = arr[a];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 so_oe after reset", so_oe, 0);

        rdsr(st); chk("R5/R2 status after reset", st, 8'hF0);
        op1(8'h06); rdsr(st); chk("R4 WEL set by clean enable", st, 8'hF2);
        op1(8'h04); rdsr(st); chk("R5 WEL cleared by disable", st, 8'hF0);
        tx[0] = 8'h06; tx[1] = 8'h00; xfer(9);
        rdsr(st); chk("R4 enable with extra bit ignored", st, 8'hF0);
        tx[0] = 8'h06; xfer(7);
        rdsr(st); chk("R13 partial enable discarded", st, 8'hF0);
        tx[0] = 8'h01; tx[1] = 8'h0C; xfer(16);
        rdsr(st); chk("R6 status write with WEL=0 dropped", st, 8'hF0);
        chk("R6 no sr_commit with WEL=0", srcom_n, 0);

        op1(8'h06);
        tx[0] = 8'h01; tx[1] = 8'hFF; xfer(16);
        rdsr(st); chk("R11 status during write cycle", st, 8'hFF);
        wait_idle;
        rdsr(st); chk("R6/R5 only BP taken, WEL cleared at end", st, 8'hFC);
        set_bp(2'b00);
        rdsr(st); chk("R6 BP cleared", st, 8'hF0);

        // Protection sweep over all four settings.
        for (int b = 0; b < 4; b++) begin
            set_bp(2'(b));
            for (int k = 0; k < 8; k++) begin
                int a;
                a = 16 * k + 5;
                op1(8'h06);
                c0 = commit_n;
                tx[0] = 8'h02; tx[1] = 8'(a); tx[2] = 8'(8'hA0 + k + 16 * b);
                xfer(24);
                chk($sformatf("R10 bp=%0d addr=%0h loads", b, a), wreq_n, guarded(a, b) ? 0 : 1);
                chk($sformatf("R8 bp=%0d addr=%0h commit", b, a), commit_n - c0, guarded(a, b) ? 0 : 1);
                if (!guarded(a, b)) exp_mem[a] = tx[2];
                wait_idle;
                op1(8'h04);
            end
        end
        set_bp(2'b00);

        // Page write with rollover inside the 16-byte page.
        op1(8'h06);
        tx[0] = 8'h0A; tx[1] = 8'h2C;
        for (int j = 0; j < 6; j++) tx[2+j] = 8'(8'h60 + j);
        xfer(64);
        chk("R8 page write load count", wreq_n, 6);
        for (int j = 0; j < 6; j++) begin
            int ea;
            ea = 'h20 + ((12 + j) % 16);
            chk($sformatf("R8 rollover load address %0d", j), log_a[j], ea);
            exp_mem[ea] = 8'(8'h60 + j);
        end
        wait_idle;
        rdsr(st); chk("R5 WEL cleared after page cycle", st, 8'hF0);

        // Write with WEL=0.
        c0 = commit_n;
        tx[0] = 8'h02; tx[1] = 8'h11; tx[2] = 8'h99; xfer(24);
        chk("R9 no load with WEL=0", wreq_n, 0);
        chk("R9 no commit with WEL=0", commit_n - c0, 0);

        // Write ending off a byte boundary.
        op1(8'h06);
        c0 = commit_n;
        tx[0] = 8'h02; tx[1] = 8'h33; tx[2] = 8'h5A; tx[3] = 8'h77; xfer(27);
        chk("R13 first byte still loaded", wreq_n, 1);
        chk("R13 no commit off byte boundary", commit_n - c0, 0);
        op1(8'h04);

        // Instructions during a write cycle.
        op1(8'h06);
        tx[0] = 8'h02; tx[1] = 8'h50; tx[2] = 8'hC3; xfer(24);
        exp_mem[8'h50] = 8'hC3;
        tx[0] = 8'h03; tx[1] = 8'h50; tx[2] = 8'h00; tx[3] = 8'h00; xfer(32);
        chk("R11 read ignored while busy", oe_bits, 0);
        rdsr(st); chk("R11 status while busy", st, 8'hF3);
        wait_idle;
        rdsr(st); chk("R5 WEL cleared after busy falls", st, 8'hF0);

        // Full streamed read with wrap, using opcode bit 3 set.
        tx[0] = 8'h0B; tx[1] = 8'h80;
        for (int j = 2; j < 133; j++) tx[j] = 8'h00;
        xfer(133 * 8);
        for (int j = 0; j < 131; j++)
            chk($sformatf("R7 stream byte %0d", j), rx[2+j], exp_mem[j % 128]);

        tx[0] = 8'h03; tx[1] = 8'h7E; tx[2] = 0; tx[3] = 0; tx[4] = 0; xfer(40);
        chk("R7 read 0x7E", rx[2], exp_mem[8'h7E]);
        chk("R7 read 0x7F", rx[3], exp_mem[8'h7F]);
        chk("R7 wrap to 0x00", rx[4], exp_mem[8'h00]);

        // Pause in the middle of a read byte.
        hold_bit = 19;
        tx[0] = 8'h03; tx[1] = 8'h10; tx[2] = 0; tx[3] = 0; tx[4] = 0; tx[5] = 0;
        xfer(48);
        hold_bit = -1;
        chk("R12 output off during pause", hold_oe, 0);
        for (int j = 0; j < 4; j++)
            chk($sformatf("R12 data intact byte %0d", j), rx[2+j], exp_mem[8'h10 + j]);

        // Exhaustive opcode sweep.
        c0 = commit_n + srcom_n;
        for (int op = 0; op < 256; op++) begin
            int expo;
            expo = (((op & 8'hF7) == 8'h03) || op == 8'h05) ? 1 : 0;
            tx[0] = 8'(op); tx[1] = 8'h00; tx[2] = 8'h00;
            xfer(24);
            chk($sformatf("R1 opcode %02h output", op), (oe_bits > 0) ? 1 : 0, expo);
        end
        chk("R1 no commits from sweep", commit_n + srcom_n - c0, 0);
        rdsr(st); chk("R1 status after sweep", st, 8'hF0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule